// File: doc/BRIEF.md
# Serial Flash Mode-Select and Access Sequencer

This block sits on the host side of a small serial flash device. The device has separate clocks for the address and the data, a control line, a mode pin, one shared data line and an end-of-process return. The host presents one command with a start address and, for writes, a 32-bit frame. The block then drives the whole pin sequence itself. It raises the mode pin and sends the control pulses that pick the operation. It shifts the address out, moves the frame, and holds the control line high while the device programs or erases. It stops when the end-of-process input answers, or flags an error if that input never arrives. Every interval is a parameter counted in system-clock cycles. At 250 MHz the defaults give 1 MHz interface clocks, 500 ns mode margins and 1 µs guards.

All pin outputs come from flops. The shared data line is split into an output, an output enable and an input, so that the pad can be placed at chip level.

Top module: `sflash_seq`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `err`, `fl_mode`, `fl_ctrl`, `fl_aclk`, `fl_dclk` and `fl_data_oe` are all 0.
- R2: When `cmd_valid` is high while idle, the command is taken at that edge, and in the next cycle `busy` and `fl_mode` are 1. The `cmd_op` encoding is 0 read, 1 frame write, 2 block erase, 3 whole-chip erase. While busy, `cmd_valid` and `cmd_op` have no effect on the pin sequence.
- R3: The mode pin stays high for MSET_CYC cycles with the control line low. Then come N control pulses, each HALF_CYC cycles high and HALF_CYC cycles low. The mode pin stays high for MSET_CYC more cycles and then falls. N is NP_READ / NP_WRITE / NP_BERASE / NP_CERASE (defaults 1 / 2 / 3 / 4).
- R4: After the mode pin falls, every interface output stays inactive for GUARD_CYC cycles.
- R5: For read, write and block erase, the address is sent MSB first, one bit per address-clock pulse. Each bit is driven with the output enable high for HALF_CYC cycles with the address clock low, then for HALF_CYC cycles with it high. Whole-chip erase sends no address.
- R6: After the last address bit, the address clock is low and the output enable is 0 for GUARD_CYC cycles before any data clock or control activity.
- R7: A read gives 32 data-clock pulses, each HALF_CYC cycles high and then HALF_CYC cycles low, with the output enable 0. The data input is sampled in the last low cycle of each pulse, MSB first. In the cycle after the last pulse, `done` is 1, `busy` is 0 and `rdata` holds the frame until the next command.
- R8: A write drives 32 frame bits MSB first. Each bit is held HALF_CYC cycles with the data clock low and then HALF_CYC cycles with it high. After that come GUARD_CYC idle cycles, and then the control line rises.
- R9: During programming the control line stays high. A write finishes at the first cycle k (counted from 0 at the control rise) in which `fl_eop` is sampled high and k ≥ PROG_MIN_CYC. In the next cycle the control line is 0, `busy` is 0 and `done` is 1 for exactly one cycle.
- R10: If `fl_eop` stays low for EXEC_LIMIT_CYC cycles of the control-high phase, the control line drops, and `done` and `err` are both 1 for one cycle.
- R11: Both erase kinds have no minimum time. They finish at the first control-high cycle in which `fl_eop` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | Operation code |
| cmd_addr | input | ADDR_W | Start address |
| cmd_wdata | input | FRAME_W | Frame to write |
| busy | output | 1 | High from command accept until completion |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion by timeout, with done |
| rdata | output | FRAME_W | Frame read back |
| fl_mode | output | 1 | Mode-select pin |
| fl_ctrl | output | 1 | Control line (mode clock or program/erase enable) |
| fl_aclk | output | 1 | Address shift clock |
| fl_dclk | output | 1 | Data clock |
| fl_data_o | output | 1 | Data line output value |
| fl_data_oe | output | 1 | Data line output enable |
| fl_data_i | input | 1 | Data line input value |
| fl_eop | input | 1 | End-of-process from the device |

## Verification
Every pin moves on a registered edge. The effect of an accepted command therefore shows one cycle after the accepting edge, and from then on each phase lasts exactly the number of cycles in the requirements. The bench keeps its own timeline of phase lengths and compares all pins at the falling clock edge of every cycle. The end-of-process input is raised at a chosen control-high cycle. Completion is then expected max(that cycle, minimum)+1 cycles after the control rise, and the timeout after EXEC_LIMIT_CYC cycles. Read data is placed on the input just after each data-clock rise, and `rdata` is checked in the `done` cycle.

// File: rtl/sflash_pkg.sv
package sflash_pkg;

  // Operation codes seen on cmd_op
  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_BERASE = 2'd2,
    OP_CERASE = 2'd3
  } sf_op_e;

  // Sequencer phases
  typedef enum logic [3:0] {
    S_IDLE,
    S_MSET,
    S_PULSE,
    S_MHOLD,
    S_MGRD,
    S_ADDR,
    S_AGRD,
    S_RD,
    S_WR,
    S_WGRD,
    S_EXEC
  } sf_state_e;

endpackage

// File: rtl/sflash_shreg.sv
module sflash_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {q[W-2:0], sin};
  end

  // R5: loading a new command never coincides with shifting a bit
  a_r5_load_not_shift: assert property (@(posedge clk) disable iff (rst)
    !(load && shift));

endmodule

// File: rtl/sflash_exec_timer.sv
module sflash_exec_timer #(
  parameter int MIN_CYC   = 100000,
  parameter int LIMIT_CYC = 13000000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic min_met,
  output logic expired
);

  localparam int CW = $clog2(LIMIT_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)                 cnt <= '0;
    else if (cnt != CW'(LIMIT_CYC))  cnt <= cnt + 1'b1;
  end

  assign min_met = (cnt >= CW'(MIN_CYC));
  assign expired = (cnt == CW'(LIMIT_CYC - 1));

  // R10: once the limit is reached the sequencer leaves the control-high phase
  a_r10_expiry_stops_run: assert property (@(posedge clk) disable iff (rst)
    expired |=> !run);

endmodule

// File: rtl/sflash_seq.sv
module sflash_seq
  import sflash_pkg::*;
#(
  parameter int ADDR_W         = 18,
  parameter int FRAME_W        = 32,
  parameter int HALF_CYC       = 125,
  parameter int MSET_CYC       = 125,
  parameter int GUARD_CYC      = 250,
  parameter int PROG_MIN_CYC   = 100000,
  parameter int EXEC_LIMIT_CYC = 13000000,
  parameter int NP_READ        = 1,
  parameter int NP_WRITE       = 2,
  parameter int NP_BERASE      = 3,
  parameter int NP_CERASE      = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [FRAME_W-1:0] cmd_wdata,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic [FRAME_W-1:0] rdata,
  output logic               fl_mode,
  output logic               fl_ctrl,
  output logic               fl_aclk,
  output logic               fl_dclk,
  output logic               fl_data_o,
  output logic               fl_data_oe,
  input  logic               fl_data_i,
  input  logic               fl_eop
);

  localparam int DMAX = (HALF_CYC > MSET_CYC)
                        ? ((HALF_CYC > GUARD_CYC) ? HALF_CYC : GUARD_CYC)
                        : ((MSET_CYC > GUARD_CYC) ? MSET_CYC : GUARD_CYC);
  localparam int DW   = $clog2(DMAX + 1);
  localparam int BMAX = (ADDR_W > FRAME_W) ? ADDR_W : FRAME_W;
  localparam int BW   = $clog2(BMAX);
  localparam int PW   = 8;

  localparam logic [DW-1:0] HALF_L  = DW'(HALF_CYC - 1);
  localparam logic [DW-1:0] MSET_L  = DW'(MSET_CYC - 1);
  localparam logic [DW-1:0] GUARD_L = DW'(GUARD_CYC - 1);

  sf_state_e         state;
  sf_op_e            op_q;
  logic [DW-1:0]     cnt;
  logic [BW-1:0]     bcnt;
  logic [PW-1:0]     pcnt;
  logic              half;
  logic              busy_q, done_q, err_q;
  logic              mode_q, ctrl_q, aclk_q, dclk_q, oe_q, src_data;
  logic              tick;
  logic              ld, a_shift, d_shift;
  logic [ADDR_W-1:0] a_q;
  logic [FRAME_W-1:0] d_q;
  logic              x_min, x_exp, x_run;

  function automatic logic [PW-1:0] pulses_for(sf_op_e op);
    case (op)
      OP_READ:   return PW'(NP_READ - 1);
      OP_WRITE:  return PW'(NP_WRITE - 1);
      OP_BERASE: return PW'(NP_BERASE - 1);
      default:   return PW'(NP_CERASE - 1);
    endcase
  endfunction

  assign tick    = (cnt == '0);
  assign ld      = (state == S_IDLE) && cmd_valid;
  assign a_shift = (state == S_ADDR) && tick && half && (bcnt != '0);
  assign d_shift = ((state == S_WR) && tick && half && (bcnt != '0)) ||
                   ((state == S_RD) && tick && !half);
  assign x_run   = (state == S_EXEC);

  sflash_shreg #(.W(ADDR_W)) addr_sr_i (
    .clk(clk), .rst(rst), .load(ld), .load_val(cmd_addr),
    .shift(a_shift), .sin(1'b0), .q(a_q)
  );

  sflash_shreg #(.W(FRAME_W)) data_sr_i (
    .clk(clk), .rst(rst), .load(ld), .load_val(cmd_wdata),
    .shift(d_shift), .sin(fl_data_i), .q(d_q)
  );

  sflash_exec_timer #(.MIN_CYC(PROG_MIN_CYC), .LIMIT_CYC(EXEC_LIMIT_CYC)) exec_tmr_i (
    .clk(clk), .rst(rst), .run(x_run), .min_met(x_min), .expired(x_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      op_q     <= OP_READ;
      cnt      <= '0;
      bcnt     <= '0;
      pcnt     <= '0;
      half     <= 1'b0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      mode_q   <= 1'b0;
      ctrl_q   <= 1'b0;
      aclk_q   <= 1'b0;
      dclk_q   <= 1'b0;
      oe_q     <= 1'b0;
      src_data <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (state == S_IDLE) begin
        if (cmd_valid) begin
          op_q   <= sf_op_e'(cmd_op);
          busy_q <= 1'b1;
          mode_q <= 1'b1;
          cnt    <= MSET_L;
          state  <= S_MSET;
        end
      end else if (state == S_EXEC) begin
        if (fl_eop && (op_q != OP_WRITE || x_min)) begin
          state  <= S_IDLE;
          ctrl_q <= 1'b0;
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else if (x_exp) begin
          state  <= S_IDLE;
          ctrl_q <= 1'b0;
          busy_q <= 1'b0;
          done_q <= 1'b1;
          err_q  <= 1'b1;
        end
      end else if (!tick) begin
        cnt <= cnt - 1'b1;
      end else begin
        case (state)
          S_MSET: begin
            state  <= S_PULSE;
            ctrl_q <= 1'b1;
            half   <= 1'b1;
            pcnt   <= pulses_for(op_q);
            cnt    <= HALF_L;
          end
          S_PULSE: begin
            if (half) begin
              ctrl_q <= 1'b0;
              half   <= 1'b0;
              cnt    <= HALF_L;
            end else if (pcnt == '0) begin
              state <= S_MHOLD;
              cnt   <= MSET_L;
            end else begin
              ctrl_q <= 1'b1;
              half   <= 1'b1;
              pcnt   <= pcnt - 1'b1;
              cnt    <= HALF_L;
            end
          end
          S_MHOLD: begin
            mode_q <= 1'b0;
            state  <= S_MGRD;
            cnt    <= GUARD_L;
          end
          S_MGRD: begin
            if (op_q == OP_CERASE) begin
              state  <= S_EXEC;
              ctrl_q <= 1'b1;
            end else begin
              state    <= S_ADDR;
              oe_q     <= 1'b1;
              src_data <= 1'b0;
              half     <= 1'b0;
              bcnt     <= BW'(ADDR_W - 1);
              cnt      <= HALF_L;
            end
          end
          S_ADDR: begin
            if (!half) begin
              aclk_q <= 1'b1;
              half   <= 1'b1;
              cnt    <= HALF_L;
            end else begin
              aclk_q <= 1'b0;
              half   <= 1'b0;
              if (bcnt == '0) begin
                oe_q  <= 1'b0;
                state <= S_AGRD;
                cnt   <= GUARD_L;
              end else begin
                bcnt <= bcnt - 1'b1;
                cnt  <= HALF_L;
              end
            end
          end
          S_AGRD: begin
            case (op_q)
              OP_READ: begin
                state  <= S_RD;
                dclk_q <= 1'b1;
                half   <= 1'b1;
                bcnt   <= BW'(FRAME_W - 1);
                cnt    <= HALF_L;
              end
              OP_WRITE: begin
                state    <= S_WR;
                oe_q     <= 1'b1;
                src_data <= 1'b1;
                half     <= 1'b0;
                bcnt     <= BW'(FRAME_W - 1);
                cnt      <= HALF_L;
              end
              default: begin
                state  <= S_EXEC;
                ctrl_q <= 1'b1;
              end
            endcase
          end
          S_RD: begin
            if (half) begin
              dclk_q <= 1'b0;
              half   <= 1'b0;
              cnt    <= HALF_L;
            end else if (bcnt == '0) begin
              state  <= S_IDLE;
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bcnt   <= bcnt - 1'b1;
              dclk_q <= 1'b1;
              half   <= 1'b1;
              cnt    <= HALF_L;
            end
          end
          S_WR: begin
            if (!half) begin
              dclk_q <= 1'b1;
              half   <= 1'b1;
              cnt    <= HALF_L;
            end else begin
              dclk_q <= 1'b0;
              half   <= 1'b0;
              if (bcnt == '0) begin
                oe_q  <= 1'b0;
                state <= S_WGRD;
                cnt   <= GUARD_L;
              end else begin
                bcnt <= bcnt - 1'b1;
                cnt  <= HALF_L;
              end
            end
          end
          S_WGRD: begin
            state  <= S_EXEC;
            ctrl_q <= 1'b1;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign err        = err_q;
  assign rdata      = d_q;
  assign fl_mode    = mode_q;
  assign fl_ctrl    = ctrl_q;
  assign fl_aclk    = aclk_q;
  assign fl_dclk    = dclk_q;
  assign fl_data_oe = oe_q;
  assign fl_data_o  = src_data ? d_q[FRAME_W-1] : a_q[ADDR_W-1];

  // R3: the control line pulses only under the mode pin or while programming
  a_r3_ctrl_needs_mode: assert property (@(posedge clk) disable iff (rst)
    fl_ctrl |-> (fl_mode || state == S_EXEC));

  // R4: the mode pin falls with every other interface output inactive
  a_r4_quiet_at_mode_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(fl_mode) |-> !(fl_ctrl || fl_aclk || fl_dclk || fl_data_oe));

  // R5: an address clock is only given while the line is driven
  a_r5_aclk_with_drive: assert property (@(posedge clk) disable iff (rst)
    fl_aclk |-> (fl_data_oe && !fl_dclk));

  // R7: the line is released while read data is clocked
  a_r7_read_released: assert property (@(posedge clk) disable iff (rst)
    (fl_dclk && op_q == OP_READ) |-> !fl_data_oe);

  // R9: the completion pulse lasts one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: an error appears only with completion
  a_r10_err_with_done: assert property (@(posedge clk) disable iff (rst)
    err |-> (done && !busy));

  // R2: busy only ends together with completion
  a_r2_busy_ends_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

endmodule

// File: tb/sflash_seq_tb.sv
`timescale 1ns/1ps
module sflash_seq_tb_top;

  localparam int AW   = 8;
  localparam int FW   = 32;
  localparam int HC   = 2;
  localparam int MS   = 3;
  localparam int GD   = 4;
  localparam int PMIN = 5;
  localparam int LIM  = 40;

  localparam logic [7:0] V_BUSY = 8'h80;
  localparam logic [7:0] V_MODE = 8'h40;
  localparam logic [7:0] V_CTRL = 8'h20;
  localparam logic [7:0] V_ACLK = 8'h10;
  localparam logic [7:0] V_DCLK = 8'h08;
  localparam logic [7:0] V_OE   = 8'h04;
  localparam logic [7:0] V_DONE = 8'h02;
  localparam logic [7:0] V_ERR  = 8'h01;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic [FW-1:0] cmd_wdata = '0;
  logic          busy, done, err;
  logic [FW-1:0] rdata;
  logic          fl_mode, fl_ctrl, fl_aclk, fl_dclk, fl_data_o, fl_data_oe;
  logic          fl_data_i = 1'b0;
  logic          fl_eop = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  sflash_seq #(
    .ADDR_W(AW), .FRAME_W(FW), .HALF_CYC(HC), .MSET_CYC(MS), .GUARD_CYC(GD),
    .PROG_MIN_CYC(PMIN), .EXEC_LIMIT_CYC(LIM),
    .NP_READ(1), .NP_WRITE(2), .NP_BERASE(3), .NP_CERASE(4)
  ) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .err(err), .rdata(rdata), .fl_mode(fl_mode), .fl_ctrl(fl_ctrl),
    .fl_aclk(fl_aclk), .fl_dclk(fl_dclk), .fl_data_o(fl_data_o),
    .fl_data_oe(fl_data_oe), .fl_data_i(fl_data_i), .fl_eop(fl_eop)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Compare all pins in one cycle against the model's expectation
  task automatic step(input string tag, input logic [7:0] exp, input logic dbit);
    logic [7:0] act;
    @(negedge clk);
    act = {busy, fl_mode, fl_ctrl, fl_aclk, fl_dclk, fl_data_oe, done, err};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: pins %b expected %b", tag, act, exp);
    end
    if (exp[2]) begin
      checks++;
      if (fl_data_o !== dbit) begin
        fails++;
        $display("FAIL %s: data_o %b expected %b", tag, fl_data_o, dbit);
      end
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [AW-1:0] ad,
                         input logic [FW-1:0] wd, input logic [FW-1:0] rv,
                         input int eop_at);
    int np, minv, len, last;
    np   = int'(op) + 1;
    minv = (op == 2'd1) ? PMIN : 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = ad; cmd_wdata = wd;
    // R2/R3: mode setup, with a different op held on the request lines
    for (int c = 0; c < MS; c++) begin
      step("R2 R3 mode setup", V_BUSY | V_MODE, 1'b0);
      cmd_op = op ^ 2'b01;
    end
    for (int p = 0; p < np; p++) begin
      for (int h = 0; h < HC; h++) step("R3 ctrl high", V_BUSY | V_MODE | V_CTRL, 1'b0);
      for (int h = 0; h < HC; h++) step("R3 ctrl low",  V_BUSY | V_MODE, 1'b0);
    end
    cmd_valid = 1'b0;
    for (int c = 0; c < MS; c++) step("R3 mode hold", V_BUSY | V_MODE, 1'b0);
    for (int c = 0; c < GD; c++) step("R4 mode guard", V_BUSY, 1'b0);
    if (op != 2'd3) begin
      for (int i = AW - 1; i >= 0; i--) begin
        for (int h = 0; h < HC; h++) step("R5 addr setup", V_BUSY | V_OE, ad[i]);
        for (int h = 0; h < HC; h++) step("R5 addr clock", V_BUSY | V_OE | V_ACLK, ad[i]);
      end
      for (int c = 0; c < GD; c++) step("R6 addr guard", V_BUSY, 1'b0);
    end
    if (op == 2'd0) begin
      for (int i = FW - 1; i >= 0; i--) begin
        for (int h = 0; h < HC; h++) begin
          step("R7 dclk high", V_BUSY | V_DCLK, 1'b0);
          if (h == 0) fl_data_i = rv[i];
        end
        for (int h = 0; h < HC; h++) step("R7 dclk low", V_BUSY, 1'b0);
      end
      step("R7 read done", V_DONE, 1'b0);
      checks++;
      if (rdata !== rv) begin
        fails++;
        $display("FAIL R7 rdata: %h expected %h", rdata, rv);
      end
      step("R7 idle after read", 8'h00, 1'b0);
      return;
    end
    if (op == 2'd1) begin
      for (int i = FW - 1; i >= 0; i--) begin
        for (int h = 0; h < HC; h++) step("R8 data setup", V_BUSY | V_OE, wd[i]);
        for (int h = 0; h < HC; h++) step("R8 data clock", V_BUSY | V_OE | V_DCLK, wd[i]);
      end
      for (int c = 0; c < GD; c++) step("R8 frame guard", V_BUSY, 1'b0);
    end
    if (eop_at < 0) len = LIM;
    else begin
      last = (eop_at > minv) ? eop_at : minv;
      len  = last + 1;
    end
    for (int k = 0; k < len; k++) begin
      step((op == 2'd1) ? "R9 programming" : "R11 erasing", V_BUSY | V_CTRL, 1'b0);
      if (k == eop_at) fl_eop = 1'b1;
    end
    if (eop_at < 0) step("R10 timeout", V_DONE | V_ERR, 1'b0);
    else            step((op == 2'd1) ? "R9 complete" : "R11 complete", V_DONE, 1'b0);
    fl_eop = 1'b0;
    step("R9 idle after completion", 8'h00, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog: 100000 cycles elapsed, expected completion earlier");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    step("R1 reset state", 8'h00, 1'b0);
    step("R1 reset state held", 8'h00, 1'b0);
    run_cmd(2'd0, 8'hA5, 32'h0, 32'hC3A5_0F96, 0);       // R7 read
    run_cmd(2'd1, 8'h3C, 32'h8001_7FFE, 32'h0, 1);       // R9 eop before minimum
    run_cmd(2'd1, 8'h01, 32'h5A5A_A5A5, 32'h0, 9);       // R9 eop after minimum
    run_cmd(2'd2, 8'hFF, 32'h0, 32'h0, 0);               // R11 block erase, immediate
    run_cmd(2'd3, 8'h77, 32'h0, 32'h0, 7);               // R11 chip erase, R5 no address
    run_cmd(2'd3, 8'h00, 32'h0, 32'h0, -1);              // R10 timeout
    run_cmd(2'd0, 8'h00, 32'hFFFF_FFFF, 32'h0000_0001, 0); // R7 second pattern
    summary();
    $finish;
  end

endmodule